// File: doc/BRIEF.md
# Mains-Referenced Time-of-Day Counter

This block keeps the time of day in hours, minutes and seconds, counting from a 60 pulse-per-second reference such as a power-line waveform squared up outside the chip. The reference arrives on one input pin and is asynchronous to the system clock. It is brought into the clock domain, and each rising edge becomes a single-cycle event. A divide-by-60 prescaler turns those events into a once-per-second enable.

The once-per-second enable drives a chain of BCD digit counters that all run on the one system clock. Seconds units and minutes units count 0 to 9. Seconds tens and minutes tens count 0 to 5. The hours stage counts 1 to 12 in twelve-hour form. Each stage moves only in a cycle where the enable passed up from the stage below it is active, so no stage uses another stage's output as a clock. The six digit outputs are plain 4-bit BCD, ready for a seven-segment decoder.

An asynchronous active-low reset, released in step with the clock, sets the time to 12:00:00 and clears the prescaler. The prescaler division is a parameter. It defaults to 60, and it can be set to 1 so that the chain can be exercised quickly.

Top module: `mains_clock_chain`

## Requirements
- R1: While reset is held, and after it is released, the outputs read 12:00:00, and the prescaler starts from zero. With the default division of 60, the first 59 rising edges after reset leave the time unchanged.
- R2: With the default division, the seconds advance by exactly one on every 60th rising edge of the reference input.
- R3: A reference input held high for many clock cycles counts as one edge. Only a low-to-high transition is counted.
- R4: Seconds units step 0,1,...,9 and then wrap to 0. The seconds tens digit increments in the same cycle as that wrap.
- R5: Seconds tens step 0 to 5. Going from 59 to 00 seconds raises the minute enable.
- R6: Minutes advance only in a cycle where the seconds read 59 and the one-second enable is active. Minutes units wrap 9 to 0 and minutes tens wrap 5 to 0, following the same digit rules as the seconds.
- R7: Hours advance only in a cycle where the time reads xx:59:59 and the one-second enable is active.
- R8: Hours run 12, 01, 02, ..., 09, 10, 11, 12. The step from 09 gives tens=1 and units=0, the step from 12 gives 01, and 00 never appears.
- R9: Without reference edges the time holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_in | input | 1 | 60 pps reference, asynchronous to clk |
| sec_lo | output | 4 | Seconds units, BCD |
| sec_hi | output | 4 | Seconds tens, BCD 0 to 5 |
| min_lo | output | 4 | Minutes units, BCD |
| min_hi | output | 4 | Minutes tens, BCD 0 to 5 |
| hr_lo | output | 4 | Hours units, BCD |
| hr_hi | output | 4 | Hours tens, 0 or 1 |

## Verification
The bench counts 59 edges after reset and confirms that the time is unchanged, then sends the 60th edge and confirms one second. A prescaler that is off by one, or that is not cleared by reset, shows up at this check. A long high pulse is also applied: a level-sensitive counter would advance on every clock cycle of that pulse instead of once. A second instance with a division of 1 is driven through 09→10 seconds, 59→00 seconds, 12:59:59→01:00:00 and 09:59:59→10:00:00. A carry that ignored a lower digit, an hours stage that passed through 00 or 13, or a 09 that became 0A would each give a wrong reading at one of these boundaries. Every expected time is computed from the total number of edges applied.

// File: rtl/mains_clock_pkg.sv
package mains_clock_pkg;
  typedef logic [3:0] bcd_t;
  localparam int unsigned UNITS_MOD = 10;
  localparam int unsigned TENS_MOD  = 6;
  localparam int unsigned N_MS_DIGITS = 4;
  localparam bcd_t HOUR_RST_HI = 4'd1;
  localparam bcd_t HOUR_RST_LO = 4'd2;
endpackage

// File: rtl/line_edge_sync.sv
module line_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_pulse = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/second_prescaler.sv
module second_prescaler #(
  parameter int unsigned DIVIDE = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  output logic tick_out
);
  localparam int unsigned CW = (DIVIDE > 1) ? $clog2(DIVIDE) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIVIDE - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last  = (cnt_q == LAST);
  assign tick_out = pulse_in & at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (pulse_in) begin
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bcd_digit.sv
module bcd_digit
  import mains_clock_pkg::*;
#(
  parameter int unsigned MODULUS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  output bcd_t digit,
  output logic carry_en
);
  localparam bcd_t TOP = bcd_t'(MODULUS - 1);

  bcd_t dig_q, dig_d;

  assign carry_en = step_en & (dig_q == TOP);
  assign digit    = dig_q;

  always_comb begin
    dig_d = dig_q;
    if (step_en) begin
      dig_d = (dig_q == TOP) ? '0 : dig_q + 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dig_q <= '0;
    else        dig_q <= dig_d;
  end
endmodule

// File: rtl/hour_stage.sv
module hour_stage
  import mains_clock_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  output bcd_t hr_hi,
  output bcd_t hr_lo
);
  bcd_t hi_q, lo_q, hi_d, lo_d;
  logic at_twelve;

  assign at_twelve = (hi_q == 4'd1) && (lo_q == 4'd2);

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (step_en) begin
      if (at_twelve) begin
        hi_d = 4'd0;
        lo_d = 4'd1;
      end else if (lo_q == 4'd9) begin
        hi_d = 4'd1;
        lo_d = 4'd0;
      end else begin
        lo_d = lo_q + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= HOUR_RST_HI;
      lo_q <= HOUR_RST_LO;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign hr_hi = hi_q;
  assign hr_lo = lo_q;
endmodule

// File: rtl/mains_clock_chain.sv
module mains_clock_chain
  import mains_clock_pkg::*;
#(
  parameter int unsigned PULSES_PER_SEC = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_in,
  output logic [3:0] sec_lo,
  output logic [3:0] sec_hi,
  output logic [3:0] min_lo,
  output logic [3:0] min_hi,
  output logic [3:0] hr_lo,
  output logic [3:0] hr_hi
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       line_rise;
  logic       sec_tick;
  logic [N_MS_DIGITS:0] chain_en;
  bcd_t       ms_digit [N_MS_DIGITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  line_edge_sync #(.SYNC_STAGES(2)) u_sync (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .async_in   (line_in),
    .rise_pulse (line_rise)
  );

  second_prescaler #(.DIVIDE(PULSES_PER_SEC)) u_pre (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pulse_in (line_rise),
    .tick_out (sec_tick)
  );

  assign chain_en[0] = sec_tick;

  for (genvar g = 0; g < N_MS_DIGITS; g++) begin : g_ms
    localparam int unsigned MODV = (g % 2 == 0) ? UNITS_MOD : TENS_MOD;
    bcd_digit #(.MODULUS(MODV)) u_dig (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .step_en  (chain_en[g]),
      .digit    (ms_digit[g]),
      .carry_en (chain_en[g+1])
    );
  end

  hour_stage u_hr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .step_en (chain_en[N_MS_DIGITS]),
    .hr_hi   (hr_hi),
    .hr_lo   (hr_lo)
  );

  assign sec_lo = ms_digit[0];
  assign sec_hi = ms_digit[1];
  assign min_lo = ms_digit[2];
  assign min_hi = ms_digit[3];
endmodule

// File: rtl/mains_clock_chain_chk.sv
module mains_clock_chain_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] sec_lo,
  input logic [3:0] sec_hi,
  input logic [3:0] min_lo,
  input logic [3:0] min_hi,
  input logic [3:0] hr_lo,
  input logic [3:0] hr_hi
);
  AST_SEC_LO_RANGE: assert property (@(posedge clk) disable iff (!rst_n) sec_lo <= 4'd9); // R4
  AST_SEC_HI_RANGE: assert property (@(posedge clk) disable iff (!rst_n) sec_hi <= 4'd5); // R5
  AST_MIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (min_lo <= 4'd9) && (min_hi <= 4'd5)); // R6
  AST_HOUR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) !((hr_hi == 4'd0) && (hr_lo == 4'd0))); // R8
  AST_HOUR_MAX: assert property (@(posedge clk) disable iff (!rst_n) (hr_hi == 4'd0) || ((hr_hi == 4'd1) && (hr_lo <= 4'd2))); // R8
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_lo != $past(sec_lo)) |-> (sec_lo == (($past(sec_lo) == 4'd9) ? 4'd0 : $past(sec_lo) + 4'd1))); // R4
  AST_MIN_ONLY_AT_59: assert property (@(posedge clk) disable iff (!rst_n)
    (min_lo != $past(min_lo)) |-> (($past(sec_hi) == 4'd5) && ($past(sec_lo) == 4'd9))); // R6
  AST_HOUR_ONLY_AT_5959: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_lo != $past(hr_lo)) |-> (($past(min_hi) == 4'd5) && ($past(min_lo) == 4'd9) &&
                                 ($past(sec_hi) == 4'd5) && ($past(sec_lo) == 4'd9))); // R7
  AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(hr_hi) == 4'd1) && ($past(hr_lo) == 4'd2) && (hr_lo != $past(hr_lo))) |->
    ((hr_hi == 4'd0) && (hr_lo == 4'd1))); // R8
endmodule

bind mains_clock_chain mains_clock_chain_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .sec_lo (sec_lo),
  .sec_hi (sec_hi),
  .min_lo (min_lo),
  .min_hi (min_hi),
  .hr_lo  (hr_lo),
  .hr_hi  (hr_hi)
);

// File: tb/mains_clock_chain_test.sv
`timescale 1ns/1ps
module mains_clock_chain_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_slow = 1'b0;
  logic line_fast = 1'b0;
  logic [3:0] s_sl, s_sh, s_ml, s_mh, s_hl, s_hh;
  logic [3:0] f_sl, f_sh, f_ml, f_mh, f_hl, f_hh;
  int total = 0;
  int bad = 0;
  int fast_secs = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mains_clock_chain uut (
    .clk(clk), .rst_n(rst_n), .line_in(line_slow),
    .sec_lo(s_sl), .sec_hi(s_sh), .min_lo(s_ml), .min_hi(s_mh), .hr_lo(s_hl), .hr_hi(s_hh)
  );

  mains_clock_chain #(.PULSES_PER_SEC(1)) uut_fast (
    .clk(clk), .rst_n(rst_n), .line_in(line_fast),
    .sec_lo(f_sl), .sec_hi(f_sh), .min_lo(f_ml), .min_hi(f_mh), .hr_lo(f_hl), .hr_hi(f_hh)
  );

  function automatic logic [23:0] pack_time(int secs);
    int h, m, s, h12;
    s = secs % 60;
    m = (secs / 60) % 60;
    h = (secs / 3600) % 12;
    h12 = (h == 0) ? 12 : h;
    return {4'(h12 / 10), 4'(h12 % 10), 4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10)};
  endfunction

  task automatic check_time(string req, logic [23:0] act, logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic slow_edges(int n, int high_len);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); line_slow = 1'b1;
      repeat (high_len) @(negedge clk);
      line_slow = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic fast_edges(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); line_fast = 1'b1;
      @(negedge clk); line_fast = 1'b0;
    end
    repeat (4) @(negedge clk);
    fast_secs += n;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    line_slow = 1'b0;
    line_fast = 1'b0;
    fast_secs = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_time("R1 during reset", {s_hh, s_hl, s_mh, s_ml, s_sh, s_sl}, pack_time(0));
    do_reset();
    check_time("R1 after release", {s_hh, s_hl, s_mh, s_ml, s_sh, s_sl}, pack_time(0));
    check_time("R1 fast after release", {f_hh, f_hl, f_mh, f_ml, f_sh, f_sl}, pack_time(0));
  endtask

  task automatic t_prescale();
    do_reset();
    slow_edges(59, 3);
    check_time("R1 R2 59 edges no change", {s_hh, s_hl, s_mh, s_ml, s_sh, s_sl}, pack_time(0));
    slow_edges(1, 3);
    check_time("R2 60th edge", {s_hh, s_hl, s_mh, s_ml, s_sh, s_sl}, pack_time(1));
    slow_edges(60, 3);
    check_time("R2 120th edge", {s_hh, s_hl, s_mh, s_ml, s_sh, s_sl}, pack_time(2));
  endtask

  task automatic t_long_high();
    do_reset();
    slow_edges(1, 80);
    slow_edges(58, 3);
    check_time("R3 long high counted once", {s_hh, s_hl, s_mh, s_ml, s_sh, s_sl}, pack_time(0));
    slow_edges(1, 3);
    check_time("R3 then 60th edge", {s_hh, s_hl, s_mh, s_ml, s_sh, s_sl}, pack_time(1));
  endtask

  task automatic t_hold();
    logic [23:0] snap;
    snap = {s_hh, s_hl, s_mh, s_ml, s_sh, s_sl};
    repeat (200) @(negedge clk);
    check_time("R9 idle hold", {s_hh, s_hl, s_mh, s_ml, s_sh, s_sl}, snap);
  endtask

  task automatic fast_to(int target, string req);
    fast_edges(target - fast_secs);
    check_time(req, {f_hh, f_hl, f_mh, f_ml, f_sh, f_sl}, pack_time(fast_secs));
  endtask

  task automatic t_chain();
    do_reset();
    fast_to(9, "R4 units at 9");
    fast_to(10, "R4 units wrap into tens");
    fast_to(59, "R5 at 59 s");
    fast_to(60, "R5 R6 59 to 00 carries minute");
    fast_to(599, "R6 at 12:09:59");
    fast_to(600, "R6 minute units wrap");
    fast_to(3599, "R7 at 12:59:59");
    fast_to(3600, "R7 R8 12 to 01");
    fast_to(9 * 3600 + 3599, "R7 at 09:59:59");
    fast_to(10 * 3600, "R8 09 to 10");
  endtask

  initial begin
    t_reset_state();
    t_prescale();
    t_long_high();
    t_hold();
    t_chain();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule